// File: doc/BRIEF.md
# Rotary-Stepped Quad-Channel DAC Driver

This block turns a quadrature rotary knob into the output code of a four-channel, 12-bit serial DAC. Each detent of the knob moves a held code up (clockwise) or down (anticlockwise) by the current step. The code saturates at both ends of the range and never wraps. A pushbutton, synchronised and debounced inside the block, switches between a coarse step and a fine step. After reset the step is coarse: 124 codes, about 100 mV on a 3.3 V full scale. The fine step is 12 codes, about 10 mV.

Whenever the held code changes, a serial controller sends one 32-bit write-and-update frame to the channel picked by the channel select. The frame is sent MSB first, with the block as bus master. The controller is a five-state machine:
- CLEAR drives the DAC clear output low during reset and for a few clocks after it.
- IDLE waits for a pending code.
- SCK_LOW and SCK_HIGH form each bit period. The data line moves only on the falling clock edge.
- GAP holds chip select high for one full serial clock period after each frame.

The transitions are:
- CLEAR→IDLE when the clear count expires.
- IDLE→SCK_LOW when a code is pending. The code and channel are latched at this point.
- SCK_LOW→SCK_HIGH after a half period.
- SCK_HIGH→SCK_LOW after a half period, if bits remain.
- SCK_HIGH→GAP after the last bit.
- GAP→IDLE after a full period.

A change that arrives during a frame stays pending, and the newest code goes out in the next frame.

Top module: `rotary_dac_ctrl`

## Requirements
- R1: While reset is asserted and for CLR_CYCLES clocks after its release, the clear output is low and chip select is high. Afterwards the clear output stays high. Out of reset, the code is RESET_CODE (0), the step is coarse, and SCK is low.
- R2: A rising edge of the synchronised A input with B low raises the code by the current step. With B high, the same edge lowers the code by the current step.
- R3: The step after reset is COARSE_STEP (124). Each debounced press toggles between COARSE_STEP and FINE_STEP (12).
- R4: The code saturates at 0 and at 4095. A detent that leaves the code unchanged sends no frame.
- R5: A button level counts only after it has differed from the accepted level for DEB_CYCLES consecutive clocks. Shorter pulses and bounces do not toggle the step.
- R6: Each frame is 32 bits, MSB first, laid out as follows:
  - 8 zero bits;
  - the command 4'b0011;
  - the address {2'b00, channel};
  - the 12-bit code;
  - 4 zero bits.
- R7: SCK is high only while chip select is low. MOSI holds still whenever SCK is high, so it changes only on falling SCK edges.
- R8: Chip select stays high for at least 2*SCK_DIV clocks between frames.
- R9: A code change made while a frame is in flight is kept. The latest code is sent in the following frame.
- R10: The channel select is sampled when a frame starts. Changing it alone sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Rotary encoder phase A (asynchronous) |
| enc_b | input | 1 | Rotary encoder phase B (asynchronous) |
| step_btn | input | 1 | Step-size pushbutton, active high, bouncy |
| chan_sel | input | 2 | DAC channel to write |
| spi_sck | output | 1 | Serial clock to DAC |
| spi_mosi | output | 1 | Serial data to DAC |
| spi_cs_n | output | 1 | Active-low chip select |
| dac_clr_n | output | 1 | Active-low clear to DAC |

## Verification
The hardest case to reach from the ports is a code change that lands while a frame is still shifting. The bench turns the knob once, waits until chip select falls, and then turns it twice more. It then expects exactly two frames: the first carrying the first value, the second carrying the newest one. The same back-to-back pair gives the bench its measurement of the chip-select gap. Saturation at the top is reached by a long run of coarse detents, each one confirmed by its frame.

// File: rtl/rdac_pkg.sv
package rdac_pkg;

    localparam int DAC_W   = 12;
    localparam int FRAME_W = 32;
    localparam logic [3:0] CMD_WRITE_UPDATE = 4'b0011;

    typedef enum logic [2:0] {
        S_CLEAR,
        S_IDLE,
        S_SCK_LOW,
        S_SCK_HIGH,
        S_GAP
    } spi_state_t;

    function automatic logic [FRAME_W-1:0] rdac_frame(
        input logic [3:0]       addr,
        input logic [DAC_W-1:0] code
    );
        return {8'h00, CMD_WRITE_UPDATE, addr, code, 4'h0};
    endfunction

endpackage

// File: rtl/rdac_quad_dec.sv
module rdac_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] raw;
    logic [1:0] sync1_q;
    logic [1:0] sync2_q;
    logic       a_prev_q;

    assign raw = {enc_b, enc_a};

    // Two-flop synchroniser per phase.
    for (genvar i = 0; i < 2; i++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync1_q[i] <= 1'b0;
                sync2_q[i] <= 1'b0;
            end else begin
                sync1_q[i] <= raw[i];
                sync2_q[i] <= sync1_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_prev_q <= 1'b0;
        else        a_prev_q <= sync2_q[0];
    end

    logic a_rise;
    assign a_rise  = sync2_q[0] & ~a_prev_q;
    assign step_up = a_rise & ~sync2_q[1];
    assign step_dn = a_rise &  sync2_q[1];

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn)); // R2
endmodule

// File: rtl/rdac_btn_filter.sv
module rdac_btn_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [1:0]       sync_q;
    logic             level_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b00;
            level_q <= 1'b0;
            cnt_q   <= '0;
            press   <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], btn_raw};
            press  <= 1'b0;
            if (sync_q[1] == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                level_q <= sync_q[1];
                cnt_q   <= '0;
                press   <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> level_q && !$past(level_q)); // R5
endmodule

// File: rtl/rdac_code_reg.sv
module rdac_code_reg #(
    parameter int W          = 12,
    parameter int COARSE     = 124,
    parameter int FINE       = 12,
    parameter int RESET_CODE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         press,
    input  logic         take,
    output logic [W-1:0] code,
    output logic         dirty
);
    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] STEP_C = W'(COARSE);
    localparam logic [W-1:0] STEP_F = W'(FINE);

    logic         fine_q;
    logic [W-1:0] code_q;
    logic [W-1:0] step_w;
    logic [W-1:0] code_nx;
    logic         changed;

    assign step_w = fine_q ? STEP_F : STEP_C;

    always_comb begin
        code_nx = code_q;
        if (step_up)
            code_nx = (code_q > TOP - step_w) ? TOP : code_q + step_w;
        else if (step_dn)
            code_nx = (code_q < step_w) ? '0 : code_q - step_w;
    end

    assign changed = (code_nx != code_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q <= 1'b0;
            code_q <= W'(RESET_CODE);
            dirty  <= 1'b0;
        end else begin
            if (press) fine_q <= ~fine_q;
            code_q <= code_nx;
            if (changed)   dirty <= 1'b1;
            else if (take) dirty <= 1'b0;
        end
    end

    assign code = code_q;

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |->
            ((code_q > $past(code_q)) ? (code_q - $past(code_q) <= STEP_C)
                                      : ($past(code_q) - code_q <= STEP_C))); // R2
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == TOP && $past(step_up)) |-> code_q == TOP); // R4
    AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == '0 && $past(step_dn)) |-> code_q == '0); // R4
    AST_MODE_BY_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_q != $past(fine_q)) |-> $past(press)); // R3
    AST_DIRTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(changed) |-> dirty); // R9
endmodule

// File: rtl/rdac_spi_tx.sv
module rdac_spi_tx
    import rdac_pkg::*;
#(
    parameter int SCK_DIV    = 2,
    parameter int CLR_CYCLES = 4,
    parameter int CH_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dirty,
    input  logic [DAC_W-1:0] code,
    input  logic [CH_W-1:0]  chan,
    output logic             take,
    output logic             spi_sck,
    output logic             spi_mosi,
    output logic             spi_cs_n,
    output logic             dac_clr_n
);
    localparam int GAP_CYCLES = 2 * SCK_DIV;
    localparam int MAX_WAIT   = (CLR_CYCLES > GAP_CYCLES) ? CLR_CYCLES : GAP_CYCLES;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);
    localparam int BIT_W      = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(SCK_DIV - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(CLR_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

    spi_state_t         state_q, state_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               cnt_done;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            S_CLEAR:    cnt_done = (cnt_q == CLR_LAST);
            S_GAP:      cnt_done = (cnt_q == GAP_LAST);
            S_IDLE:     cnt_done = 1'b0;
            default:    cnt_done = (cnt_q == HALF_LAST);
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_CLEAR:    if (cnt_done) state_nx = S_IDLE;
            S_IDLE:     if (dirty)    state_nx = S_SCK_LOW;
            S_SCK_LOW:  if (cnt_done) state_nx = S_SCK_HIGH;
            S_SCK_HIGH: if (cnt_done) state_nx = (bit_q == BIT_LAST) ? S_GAP : S_SCK_LOW;
            S_GAP:      if (cnt_done) state_nx = S_IDLE;
            default:    state_nx = S_CLEAR;
        endcase
    end

    assign take = (state_q == S_IDLE) && dirty;

    // Datapath: counters and shift register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else begin
            if (state_nx != state_q || state_q == S_IDLE) cnt_q <= '0;
            else                                          cnt_q <= cnt_q + 1'b1;
            if (take) begin
                shreg_q <= rdac_frame(4'(chan), code);
                bit_q   <= '0;
            end else if (state_q == S_SCK_HIGH && cnt_done) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    // Output decode.
    always_comb begin
        spi_sck   = 1'b0;
        spi_cs_n  = 1'b1;
        dac_clr_n = 1'b1;
        unique case (state_q)
            S_CLEAR:    dac_clr_n = 1'b0;
            S_SCK_LOW:  spi_cs_n  = 1'b0;
            S_SCK_HIGH: begin spi_cs_n = 1'b0; spi_sck = 1'b1; end
            default:    ;
        endcase
    end

    assign spi_mosi = shreg_q[FRAME_W-1];

    AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n); // R7
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi)); // R7
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> spi_cs_n); // R1
    AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !spi_cs_n && !spi_sck); // R9
endmodule

// File: rtl/rotary_dac_ctrl.sv
module rotary_dac_ctrl
    import rdac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int COARSE_STEP = 124,
    parameter int FINE_STEP   = 12,
    parameter int DEB_CYCLES  = 4,
    parameter int SCK_DIV     = 2,
    parameter int CLR_CYCLES  = 4,
    parameter int RESET_CODE  = 0,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            step_btn,
    input  logic [CH_W-1:0] chan_sel,
    output logic            spi_sck,
    output logic            spi_mosi,
    output logic            spi_cs_n,
    output logic            dac_clr_n
);
    logic             step_up, step_dn, press, take, dirty;
    logic [DAC_W-1:0] code;

    rdac_quad_dec u_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .step_up(step_up), .step_dn(step_dn)
    );

    rdac_btn_filter #(.STABLE_CYCLES(DEB_CYCLES)) u_btn (
        .clk(clk), .rst_n(rst_n), .btn_raw(step_btn), .press(press)
    );

    rdac_code_reg #(
        .W(DAC_W), .COARSE(COARSE_STEP), .FINE(FINE_STEP), .RESET_CODE(RESET_CODE)
    ) u_code (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .press(press), .take(take), .code(code), .dirty(dirty)
    );

    rdac_spi_tx #(.SCK_DIV(SCK_DIV), .CLR_CYCLES(CLR_CYCLES), .CH_W(CH_W)) u_spi (
        .clk(clk), .rst_n(rst_n), .dirty(dirty), .code(code), .chan(chan_sel),
        .take(take), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .dac_clr_n(dac_clr_n)
    );
endmodule

// File: tb/tb_rotary_dac_ctrl.sv
module tb_rotary_dac_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SCK_DIV    = 2;
    localparam int DEB        = 4;
    localparam int CLR_CYC    = 4;
    localparam int WIN        = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_a = 1'b0, enc_b = 1'b0, step_btn = 1'b0;
    logic [1:0] chan_sel = 2'd0;
    logic       spi_sck, spi_mosi, spi_cs_n, dac_clr_n;

    rotary_dac_ctrl #(.SCK_DIV(SCK_DIV), .DEB_CYCLES(DEB), .CLR_CYCLES(CLR_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .step_btn(step_btn),
        .chan_sel(chan_sel), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .dac_clr_n(dac_clr_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Frame monitor.
    logic [31:0] cap = '0;
    int          nbits = 0;
    logic [31:0] frames [0:255];
    int          nfr = 0;
    time         t_rise = 0;
    int          min_gap = 1000000;

    always @(posedge spi_sck) if (!spi_cs_n) begin
        cap   = {cap[30:0], spi_mosi};
        nbits = nbits + 1;
    end
    always @(posedge spi_cs_n) begin
        if (nbits == 32 && nfr < 256) begin
            frames[nfr] = cap;
            nfr = nfr + 1;
        end
        nbits  = 0;
        t_rise = $time;
    end
    always @(negedge spi_cs_n) if (t_rise != 0) begin
        if (int'(($time - t_rise) / CLK_PERIOD) < min_gap)
            min_gap = int'(($time - t_rise) / CLK_PERIOD);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [1:0] ch, input logic [11:0] c);
        return {8'h00, 4'b0011, 2'b00, ch, c, 4'h0};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rotate(input bit ccw);
        enc_b = ccw; cyc(3);
        enc_a = 1'b1; cyc(4);
        enc_a = 1'b0; cyc(2);
        enc_b = 1'b0; cyc(3);
    endtask

    task automatic push();
        step_btn = 1'b1; cyc(DEB + 6);
        step_btn = 1'b0; cyc(DEB + 6);
    endtask

    task automatic wait_frames(input int target, input int maxc);
        for (int i = 0; i < maxc && nfr < target; i++) cyc(1);
        cyc(2);
    endtask

    // Table: {op[1:0] (0 cw, 1 ccw, 2 press), chan[1:0], code[11:0], frame}
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {2'd1, 2'd0, 12'd0,   1'b0},
        {2'd0, 2'd1, 12'd124, 1'b1},
        {2'd0, 2'd1, 12'd248, 1'b1},
        {2'd2, 2'd1, 12'd248, 1'b0},
        {2'd0, 2'd2, 12'd260, 1'b1},
        {2'd1, 2'd2, 12'd248, 1'b1},
        {2'd1, 2'd3, 12'd236, 1'b1},
        {2'd2, 2'd3, 12'd236, 1'b0},
        {2'd1, 2'd3, 12'd112, 1'b1},
        {2'd1, 2'd0, 12'd0,   1'b1},
        {2'd1, 2'd0, 12'd0,   1'b0},
        {2'd0, 2'd0, 12'd124, 1'b1}
    };

    initial begin
        int base;
        int model;
        // R1: reset state
        cyc(3);
        check(dac_clr_n == 1'b0, "R1 clear low in reset", dac_clr_n, 0);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 cs high sck low in reset", {spi_cs_n, spi_sck}, 2);
        rst_n = 1'b1;
        cyc(1);
        check(dac_clr_n == 1'b0, "R1 clear held after reset", dac_clr_n, 0);
        cyc(CLR_CYC + 2);
        check(dac_clr_n == 1'b1, "R1 clear released", dac_clr_n, 1);
        cyc(WIN);
        check(nfr == 0, "R1 no frame after reset", nfr, 0);

        // Table walk: R2 R3 R4 R6 R10
        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic [1:0]  ch;
            logic [11:0] ec;
            bit          ef;
            {op, ch, ec, ef} = VEC[k];
            chan_sel = ch;
            base = nfr;
            if (op == 2'd2) push();
            else rotate(op == 2'd1);
            if (ef) begin
                wait_frames(base + 1, WIN);
                check(nfr == base + 1, "R2/R3 frame count", nfr - base, 1);
                if (nfr > base)
                    check(frames[base] == exp_frame(ch, ec), "R6/R4 frame content",
                          int'(frames[base]), int'(exp_frame(ch, ec)));
            end else begin
                cyc(WIN);
                check(nfr == base, "R4/R3 no frame expected", nfr - base, 0);
            end
        end

        // R9: changes during a frame; also produces back-to-back frames for R8
        base = nfr;
        rotate(1'b0);
        for (int i = 0; i < 100 && spi_cs_n; i++) cyc(1);
        rotate(1'b0);
        rotate(1'b0);
        wait_frames(base + 2, 2 * WIN);
        check(nfr == base + 2, "R9 two frames", nfr - base, 2);
        check(frames[base] == exp_frame(2'd0, 12'd248), "R9 first frame",
              int'(frames[base][15:4]), 248);
        check(frames[base + 1] == exp_frame(2'd0, 12'd496), "R9 latest code sent",
              int'(frames[base + 1][15:4]), 496);

        // R5: short glitch must not toggle step
        step_btn = 1'b1; cyc(2); step_btn = 1'b0; cyc(DEB + 6);
        base = nfr;
        rotate(1'b0);
        wait_frames(base + 1, WIN);
        check(nfr == base + 1 && frames[base][15:4] == 12'd620, "R5 glitch ignored",
              int'(frames[base][15:4]), 620);

        // R10: channel change alone sends nothing, then new channel used
        base = nfr;
        chan_sel = 2'd2;
        cyc(WIN);
        check(nfr == base, "R10 channel change silent", nfr - base, 0);

        // R4: saturate at top with coarse steps
        model = 620;
        while (model < 4095) begin
            base = nfr;
            rotate(1'b0);
            model = (model + 124 > 4095) ? 4095 : model + 124;
            wait_frames(base + 1, WIN);
        end
        check(frames[nfr - 1] == exp_frame(2'd2, 12'd4095), "R4/R10 top saturation",
              int'(frames[nfr - 1][15:4]), 4095);
        base = nfr;
        rotate(1'b0);
        cyc(WIN);
        check(nfr == base, "R4 no frame at top", nfr - base, 0);

        // R5 R3: bouncy press then fine step down
        for (int i = 0; i < 4; i++) begin
            step_btn = 1'b1; cyc(1); step_btn = 1'b0; cyc(1);
        end
        step_btn = 1'b1; cyc(DEB + 8); step_btn = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(1); step_btn = 1'b1; cyc(1); step_btn = 1'b0;
        end
        cyc(DEB + 8);
        base = nfr;
        rotate(1'b1);
        wait_frames(base + 1, WIN);
        check(nfr == base + 1 && frames[base][15:4] == 12'd4083, "R5/R3 bouncy press one toggle",
              int'(frames[base][15:4]), 4083);

        // R8: gap between frames
        check(min_gap >= 2 * SCK_DIV && min_gap < 1000000, "R8 cs gap", min_gap, 2 * SCK_DIV);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule